// File: doc/BRIEF.md
# Bus-Switch Control Register Slave

This block is the two-wire serial slave that owns the single 8-bit control byte of a buffered four-branch bus switch. It watches the upstream clock and data pins. It oversamples them on a fast system clock and recognises START and STOP conditions. It answers to a 7-bit address made of a fixed upper nibble and three strap pins. A write transfer delivers one byte. A read transfer returns the byte currently in force.

A written byte does not act at once. It waits in a pending copy and takes effect only when the transfer ends with STOP. A new START that arrives first throws the pending copy away. The block asserts a single open-drain pull-down request for the data line and never touches the clock line. Four channel enables and one clock-direction flag are taken straight from the active byte.

Top module: `busswitch_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the active byte is 0x00, so `ch_en` is 0, `clk_dir` is 0 and `sda_pull` is 0.
- R2: The slave address is `{4'b1110, addr_strap}`, sent MSB first, followed by the R/W bit. A frame with any other address gets no acknowledge (data line stays high in the 9th slot) and changes nothing.
- R3: With R/W = 0 and a matching address, the address and the first data byte are both acknowledged (data line pulled low in their 9th slots). Outputs keep their old value until STOP.
- R4: A STOP that follows an acknowledged write byte copies the pending byte into the active byte, and outputs follow within three system clocks. A STOP with nothing pending changes nothing.
- R5: A START or repeated START seen before STOP discards the pending byte, so a later STOP leaves the active byte unchanged.
- R6: With R/W = 1 and a matching address, the slave returns the active byte, not the pending byte, MSB first. After a master acknowledge it sends the byte again. After a master non-acknowledge it releases the line.
- R7: Active bit n (n = 0..3) drives `ch_en[n]` (1 = enabled). Active bit 7 drives `clk_dir` (1 = reversed). Bits 6:4 are stored and read back but drive nothing.
- R8: The slave stays addressable and writable when bit 7 of the active byte is 1.
- R9: In a write, data bytes after the first are not acknowledged and do not replace the pending byte.
- R10: `sda_pull` is high only during the slave's own acknowledge slots and its read bits that are 0. It changes only while the synchronised clock is low, and is low in the cycle after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or pin) |
| scl_i | input | 1 | Upstream bus clock as seen on the pad |
| sda_i | input | 1 | Upstream bus data as seen on the pad (wired-AND) |
| addr_strap | input | 3 | Low three address bits from strap pins |
| sda_pull | output | 1 | 1 = pull the upstream data line low |
| ch_en | output | 4 | Per-branch enable, bit n for branch n |
| clk_dir | output | 1 | 0 = upstream clock drives branches, 1 = reversed |

## Verification
The assertions assume a well-behaved master. It changes data only while the clock is low, except when it makes START and STOP. It holds every clock phase for several system clocks, so a synchronised edge is never missed. It never makes a START or STOP while the slave is pulling data low. The bench master keeps to this with quarter-bit phases of eight system clocks and with its data changes placed a full quarter-bit away from clock edges. It only issues STOP or repeated START after the slave has released the line. The strap pins change only between transfers.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam int N_CH    = 4;
    localparam int STRAP_W = 3;
    localparam int DIR_BIT = DATA_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WDATA,
        ST_ACK_W,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } eng_st_e;

    typedef struct packed {
        eng_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [DATA_W-1:0]   sr;
        logic                rw;
        logic [DATA_W-1:0]   tx;
        logic                nack;
        logic [DATA_W-1:0]   shadow;
        logic                pend;
        logic [DATA_W-1:0]   active;
    } eng_s;
endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/swctl_cond.sv
module swctl_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } cond_s;

    cond_s c_d, c_q;

    always_comb begin
        c_d.scl_p = scl_s;
        c_d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        else        c_q <= c_d;
    end

    // both clock samples high: a data edge is a bus condition
    assign scl_rise  = scl_s & ~c_q.scl_p;
    assign scl_fall  = ~scl_s & c_q.scl_p;
    assign start_det = scl_s & c_q.scl_p & c_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & c_q.scl_p & ~c_q.sda_p & sda_s;
endmodule

// File: rtl/swctl_engine.sv
module swctl_engine
    import swctl_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] addr_strap,
    output logic               sda_pull,
    output logic [DATA_W-1:0]  active
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    eng_s e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (start_det) begin
            e_d.st   = ST_ADDR;
            e_d.cnt  = '0;
            e_d.pend = 1'b0;
        end else if (stop_det) begin
            if (e_q.pend) e_d.active = e_q.shadow;
            e_d.pend = 1'b0;
            e_d.st   = ST_IDLE;
        end else begin
            unique case (e_q.st)
                ST_ADDR: begin
                    if (scl_rise && e_q.cnt != FULL) begin
                        e_d.sr  = {e_q.sr[DATA_W-2:0], sda_s};
                        e_d.cnt = e_q.cnt + 1'b1;
                    end else if (scl_fall && e_q.cnt == FULL) begin
                        if (e_q.sr[DATA_W-1:1] == {ADDR_HI, addr_strap}) begin
                            e_d.st = ST_ACK_A;
                            e_d.rw = e_q.sr[0];
                        end else begin
                            e_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        e_d.cnt = '0;
                        if (e_q.rw) begin
                            e_d.st = ST_RDATA;
                            e_d.tx = e_q.active;
                        end else begin
                            e_d.st = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise && e_q.cnt != FULL) begin
                        e_d.sr  = {e_q.sr[DATA_W-2:0], sda_s};
                        e_d.cnt = e_q.cnt + 1'b1;
                    end else if (scl_fall && e_q.cnt == FULL) begin
                        e_d.st     = ST_ACK_W;
                        e_d.shadow = e_q.sr;
                        e_d.pend   = 1'b1;
                    end
                end
                ST_ACK_W: begin
                    if (scl_fall) e_d.st = ST_SKIP;
                end
                ST_RDATA: begin
                    if (scl_rise && e_q.cnt != FULL) begin
                        e_d.cnt = e_q.cnt + 1'b1;
                    end else if (scl_fall && e_q.cnt == FULL) begin
                        e_d.st = ST_RACK;
                    end else if (scl_fall && e_q.cnt != '0) begin
                        e_d.tx = {e_q.tx[DATA_W-2:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        e_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (!e_q.nack) begin
                            e_d.st  = ST_RDATA;
                            e_d.tx  = e_q.active;
                            e_d.cnt = '0;
                        end else begin
                            e_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign sda_pull = (e_q.st == ST_ACK_A) || (e_q.st == ST_ACK_W) ||
                      ((e_q.st == ST_RDATA) && !e_q.tx[DATA_W-1]);
    assign active   = e_q.active;
endmodule

// File: rtl/busswitch_ctl.sv
module busswitch_ctl
    import swctl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b1110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_strap,
    output logic               sda_pull,
    output logic [N_CH-1:0]    ch_en,
    output logic               clk_dir
);
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] active;

    swctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    swctl_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    swctl_engine #(.ADDR_HI(ADDR_HI)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_strap (addr_strap),
        .sda_pull   (sda_pull),
        .active     (active)
    );

    assign ch_en   = active[N_CH-1:0];
    assign clk_dir = active[DIR_BIT];
endmodule

// File: rtl/swctl_chk.sv
module swctl_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_s,
    input logic            start_det,
    input logic            stop_det,
    input logic            sda_pull,
    input logic [N_CH-1:0] ch_en,
    input logic            clk_dir
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (ch_en == '0 && !clk_dir && !sda_pull)); // R1

    AST_CHANGE_ONLY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({clk_dir, ch_en}) |-> $past(stop_det)); // R4

    AST_START_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> $stable({clk_dir, ch_en})); // R5

    AST_PULL_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s); // R10

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull); // R10
endmodule

bind busswitch_ctl swctl_chk #(.N_CH(swctl_pkg::N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .ch_en     (ch_en),
    .clk_dir   (clk_dir)
);

// File: tb/busswitch_ctl_tb.sv
module busswitch_ctl_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_pull;
    logic [3:0] ch_en;
    logic       clk_dir;
    wire        sda_bus = m_sda & ~sda_pull;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural model
    logic [7:0] exp_act = 8'h00;
    logic [7:0] m_shadow = 8'h00;
    bit         m_pend = 1'b0;
    logic [7:0] d1, d2, d3;

    always #2.5 clk = ~clk;

    busswitch_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .addr_strap (strap),
        .sda_pull   (sda_pull),
        .ch_en      (ch_en),
        .clk_dir    (clk_dir)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // model output delayed by the synchroniser and engine registers
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d1 <= 8'h00; d2 <= 8'h00; d3 <= 8'h00;
        end else begin
            d1 <= exp_act; d2 <= d1; d3 <= d2;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done)
            check("R4 R7 per-clock outputs", {27'd0, clk_dir, ch_en}, {27'd0, d3[7], d3[3:0]});
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        m_sda = b;     qwait();
        m_scl = 1'b1;  qwait();
        seen = sda_bus; qwait();
        m_scl = 1'b0;  qwait();
    endtask

    task automatic bus_start();
        m_sda = 1'b1;  qwait();
        m_scl = 1'b1;  qwait();
        m_sda = 1'b0;  qwait();
        m_scl = 1'b0;  qwait();
        m_pend = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;  qwait();
        m_scl = 1'b1;  qwait();
        m_sda = 1'b1;
        if (m_pend) exp_act = m_shadow;
        m_pend = 1'b0;
        qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(v[i], s);
        bit_io(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            v[i] = s;
        end
        bit_io(~m_ack, s);
    endtask

    function automatic logic match(input logic [6:0] a);
        return a == {4'b1110, strap};
    endfunction

    task automatic wr_frame(input logic [6:0] a, input logic [7:0] v, input string tag);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check({tag, " R2 addr ack"}, {31'd0, ack}, {31'd0, match(a)});
        send_byte(v, ack);
        check({tag, " R3 data ack"}, {31'd0, ack}, {31'd0, match(a)});
        if (match(a)) begin m_shadow = v; m_pend = 1'b1; end
        check({tag, " R3 no effect before stop"}, {27'd0, clk_dir, ch_en}, {27'd0, exp_act[7], exp_act[3:0]});
    endtask

    task automatic rd_frame(input int nbytes, input string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte({4'b1110, strap, 1'b1}, ack);
        check({tag, " R6 read addr ack"}, {31'd0, ack}, 32'd1);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k != nbytes - 1, v);
            check({tag, " R6 read data"}, {24'd0, v}, {24'd0, exp_act});
        end
    endtask

    initial begin
        logic ack;
        repeat (4) @(negedge clk);
        check("R1 reset ch_en", {28'd0, ch_en}, 32'd0);
        check("R1 reset clk_dir", {31'd0, clk_dir}, 32'd0);
        check("R10 reset pull", {31'd0, sda_pull}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after release", {27'd0, clk_dir, ch_en}, 32'd0);

        // basic write, commit on stop
        wr_frame(7'b1110101, 8'h05, "w1");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R4 commit", {28'd0, ch_en}, 32'h5);
        check("R10 released idle", {31'd0, sda_pull}, 32'd0);
        rd_frame(1, "r1");
        bus_stop();

        // wrong address ignored
        wr_frame(7'b1110001, 8'hFF, "bad");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R2 mismatch ignored", {28'd0, ch_en}, 32'h5);

        // repeated start discards pending value
        wr_frame(7'b1110101, 8'hF3, "rs");
        rd_frame(1, "rs read");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R5 pending dropped", {27'd0, clk_dir, ch_en}, 32'h5);

        // direction bit, then addressable while reversed
        wr_frame(7'b1110101, 8'h80, "dir");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R7 clk_dir set", {27'd0, clk_dir, ch_en}, 32'h10);
        wr_frame(7'b1110101, 8'h7A, "rev");
        bus_stop();
        repeat (4) @(negedge clk);
        check("R8 written while reversed", {27'd0, clk_dir, ch_en}, 32'h0A);
        rd_frame(3, "r7");
        bus_stop();

        // extra write bytes refused
        strap = 3'b010;
        wr_frame(7'b1110010, 8'h0F, "multi");
        send_byte(8'hFF, ack);
        check("R9 extra byte nack", {31'd0, ack}, 32'd0);
        bus_stop();
        repeat (4) @(negedge clk);
        check("R9 first byte kept", {27'd0, clk_dir, ch_en}, 32'h0F);
        rd_frame(1, "r9");
        bus_stop();

        // stop with nothing pending
        bus_start();
        bus_stop();
        repeat (4) @(negedge clk);
        check("R4 empty stop", {28'd0, ch_en}, 32'hF);

        // pin reset clears register
        rst_n = 1'b0;
        exp_act = 8'h00; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pin reset", {27'd0, clk_dir, ch_en}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_frame(1, "r1 post reset");
        bus_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule